// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Controller

This block holds two pieces of processor state: the global interrupt enable bit (IME) and the low-power halted state. The instruction sequencer tells it when an instruction finishes, and which kind it was: a disable, an enable, a return from a handler, or a halt. The block compares the interrupt mask against the interrupt flag lines to find out whether any source is live. It then decides whether to ask the dispatch logic to service an interrupt, whether the core stays halted, and whether the next program-counter increment must be suppressed.

An enable instruction arms a one-instruction delay. The bit is set only when the instruction after it finishes. A return from a handler sets the bit with no delay. A disable clears the bit, and it also cancels an armed enable.

A halt has three outcomes, chosen by the enable bit and by whether an interrupt is already live at that moment:
- **Enable bit set:** the core sleeps until dispatch is acknowledged.
- **Enable bit clear, nothing live:** the core sleeps until a source becomes live. It then wakes without dispatch.
- **Enable bit clear, a source already live:** the core does not sleep. It raises the no-increment flag, so the byte after the halt is fetched twice.

Top module: `ime_halt_ctrl`

## Requirements
- R1: While reset is asserted, the enable bit, the halted output and the no-increment flag all go to 0, and any armed enable is dropped. A plain instruction completing after reset leaves the enable bit at 0.
- R2: `irq_req` is high exactly when the enable bit is 1 and at least one bit position is 1 in both `int_en` and `int_flag`.
- R3: A completed disable (`op_di`) clears the enable bit in the following cycle.
- R4: A completed enable (`op_ei`) leaves the enable bit unchanged. The bit becomes 1 in the cycle after the next completed instruction that is not a disable.
- R5: A disable that completes while an enable is armed cancels it, so the enable bit stays 0 after later instructions.
- R6: A completed return-from-handler (`op_reti`) sets the enable bit in the following cycle.
- R7: `irq_ack` clears the enable bit, the halted state and any armed enable in the following cycle. It leaves the no-increment flag unchanged.
- R8: A halt completing with the enable bit at 1 sets `halted`. `halted` stays 1 until `irq_ack`, and `irq_req` rises while halted once a source is live.
- R9: A halt completing with the enable bit at 0 and no live source sets `halted`. The cycle after a source becomes live, `halted` returns to 0 and `irq_req` stays 0.
- R10: A halt completing with the enable bit at 0 and a live source leaves `halted` at 0 and sets `skip_pc_inc`. The flag holds until the next completed instruction, after which it is 0.
- R11: A halt immediately after an enable picks its outcome using the enable bit as it was before the enable. The enable bit still becomes 1 when that halt completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | An instruction completes this cycle |
| op_di | input | 1 | The completing instruction is a disable |
| op_ei | input | 1 | The completing instruction is an enable |
| op_reti | input | 1 | The completing instruction is a return from handler |
| op_halt | input | 1 | The completing instruction is a halt |
| int_en | input | IRQ_W | Interrupt mask |
| int_flag | input | IRQ_W | Interrupt request flags |
| irq_ack | input | 1 | Dispatch logic accepts the request |
| ime | output | 1 | Interrupt master enable |
| halted | output | 1 | Core is in the halted state |
| irq_req | output | 1 | Request to dispatch an interrupt |
| skip_pc_inc | output | 1 | Suppress the next program-counter increment |

## Verification
The assertions assume three things about the inputs:
- At most one opcode strobe is high, and only together with `instr_done`.
- `irq_ack` never coincides with `instr_done`.
- No instruction completes while the core is halted.

The stimulus table follows these rules in every row. Each row raises at most one strobe. An acknowledge always gets a row of its own. While `halted` is 1, the only rows are idle rows or an acknowledge.

// File: rtl/ime_halt_ctrl.sv
module ime_halt_ctrl #(
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic             op_di,
  input  logic             op_ei,
  input  logic             op_reti,
  input  logic             op_halt,
  input  logic [IRQ_W-1:0] int_en,
  input  logic [IRQ_W-1:0] int_flag,
  input  logic             irq_ack,
  output logic             ime,
  output logic             halted,
  output logic             irq_req,
  output logic             skip_pc_inc
);

  logic ime_q, armed_q, halt_q, skip_q;
  logic live, halt_bug, halt_sleep, wake_plain;

  assign live       = |(int_en & int_flag);
  assign halt_bug   = instr_done && op_halt && !ime_q && live;
  assign halt_sleep = instr_done && op_halt && !halt_bug;
  assign wake_plain = halt_q && !ime_q && live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime_q   <= 1'b0;
      armed_q <= 1'b0;
      halt_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else if (irq_ack) begin
      ime_q   <= 1'b0;
      armed_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      if (instr_done) begin
        skip_q <= halt_bug;
        if (op_di) begin
          ime_q   <= 1'b0;
          armed_q <= 1'b0;
        end else if (op_reti) begin
          ime_q   <= 1'b1;
          armed_q <= 1'b0;
        end else if (op_ei) begin
          if (armed_q) ime_q <= 1'b1;
          armed_q <= 1'b1;
        end else if (armed_q) begin
          ime_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end
      if (halt_sleep)      halt_q <= 1'b1;
      else if (wake_plain) halt_q <= 1'b0;
    end
  end

  assign ime         = ime_q;
  assign halted      = halt_q;
  assign irq_req     = ime_q && live;
  assign skip_pc_inc = skip_q;

endmodule

module ime_halt_ctrl_chk #(
  parameter int IRQ_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_done,
  input logic             op_di,
  input logic             op_ei,
  input logic             op_reti,
  input logic             op_halt,
  input logic [IRQ_W-1:0] int_en,
  input logic [IRQ_W-1:0] int_flag,
  input logic             irq_ack,
  input logic             ime,
  input logic             halted,
  input logic             irq_req,
  input logic             skip_pc_inc
);
  logic pend;
  assign pend = |(int_en & int_flag);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!ime && !halted && !skip_pc_inc));

  a_r2_req_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ime && pend));

  a_r3_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && op_di && !irq_ack) |=> !ime);

  a_r4_ei_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && op_ei && !ime && !irq_ack) |=> !ime);

  a_r6_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && op_reti && !irq_ack) |=> ime);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!ime && !halted));

  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && ime && !irq_ack) |=> halted);

  a_r9_plain_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ime && pend && !irq_ack) |=> !halted);

  a_r10_bug_path: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && op_halt && !ime && pend && !irq_ack) |=> (skip_pc_inc && !halted));
endmodule

bind ime_halt_ctrl ime_halt_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/tb_ime_halt_ctrl.sv
module tb_ime_halt_ctrl;
  localparam int W = 5;
  localparam int N = 23;

  logic clk = 0, rst_n = 0;
  logic instr_done = 0, op_di = 0, op_ei = 0, op_reti = 0, op_halt = 0, irq_ack = 0;
  logic [W-1:0] int_en = '1, int_flag = '0;
  logic ime, halted, irq_req, skip_pc_inc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ime_halt_ctrl #(.IRQ_W(W)) dut (.*);

  // {tag, done di ei reti halt ack, live, exp ime halted skip req}
  localparam logic [14:0] VEC [N] = '{
    {4'd6,  6'b100100, 1'b0, 4'b1000},  // R6
    {4'd2,  6'b000000, 1'b1, 4'b1001},  // R2
    {4'd7,  6'b000001, 1'b1, 4'b0000},  // R7
    {4'd4,  6'b101000, 1'b0, 4'b0000},  // R4
    {4'd4,  6'b100000, 1'b0, 4'b1000},  // R4
    {4'd3,  6'b110000, 1'b0, 4'b0000},  // R3
    {4'd4,  6'b101000, 1'b0, 4'b0000},  // R4
    {4'd5,  6'b110000, 1'b0, 4'b0000},  // R5
    {4'd5,  6'b100000, 1'b0, 4'b0000},  // R5
    {4'd9,  6'b100010, 1'b0, 4'b0100},  // R9
    {4'd9,  6'b000000, 1'b0, 4'b0100},  // R9
    {4'd9,  6'b000000, 1'b1, 4'b0000},  // R9
    {4'd10, 6'b100010, 1'b1, 4'b0010},  // R10
    {4'd10, 6'b000000, 1'b1, 4'b0010},  // R10
    {4'd10, 6'b100000, 1'b0, 4'b0000},  // R10
    {4'd6,  6'b100100, 1'b0, 4'b1000},  // R6
    {4'd8,  6'b100010, 1'b0, 4'b1100},  // R8
    {4'd8,  6'b000000, 1'b1, 4'b1101},  // R8
    {4'd8,  6'b000001, 1'b1, 4'b0000},  // R8
    {4'd4,  6'b101000, 1'b0, 4'b0000},  // R4
    {4'd11, 6'b100010, 1'b1, 4'b1011},  // R11
    {4'd7,  6'b000001, 1'b0, 4'b0010},  // R7
    {4'd10, 6'b100000, 1'b0, 4'b0000}   // R10
  };

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {ime, halted, skip_pc_inc, irq_req};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ime/halted/skip/req actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] ctl, input logic lv);
    {instr_done, op_di, op_ei, op_reti, op_halt, irq_ack} = ctl;
    int_flag = lv ? 5'h04 : 5'h00;
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", 4'b0000);
    rst_n = 1;
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][10:5], VEC[i][4]);
      check($sformatf("R%0d step %0d", VEC[i][14:11], i), VEC[i][3:0]);
    end
    drive(6'b0, 1'b0);

    // R2: mask gates the flags
    drive(6'b100100, 1'b0);
    int_en = 5'h00; int_flag = 5'h1F; #1;
    check("R2 mask zero", 4'b1000);
    int_en = 5'h10; #1;
    check("R2 mask hit", 4'b1001);
    int_en = '1; int_flag = '0; #1;

    // R1: reset drops ime, halted and an armed enable
    drive(6'b101000, 1'b0);
    drive(6'b100010, 1'b0);
    check("R1 pre", 4'b1100);
    drive(6'b101000, 1'b0);
    rst_n = 0;
    drive(6'b000000, 1'b0);
    check("R1 reset", 4'b0000);
    rst_n = 1;
    drive(6'b100000, 1'b0);
    check("R1 armed dropped", 4'b0000);

    // R3: disable after enabled
    drive(6'b100100, 1'b0);
    drive(6'b110000, 1'b0);
    check("R3 disable", 4'b0000);
    drive(6'b0, 1'b0);
    finish_run();
  end
endmodule